// File: doc/BRIEF.md
# Two-Level Inclusive Line Coherence Controller

This block is the per-line decision logic of a middle cache level that sits between one private inner cache and a shared outer cache. Each cycle it may take one already-decoded event for a single line, along with that line's present state and dirty bit, which come from the tag array. One cycle later it returns the line's next state, a vector of action strobes and a stall flag. The tag and data arrays, the tracking-entry table and the message queues live outside and act on the strobes.

Every stable state has two forms. In one, the inner cache also holds the line (the `_IN` forms). In the other, only this level holds it. Before a line held inside can be downgraded or dropped, the controller sends the inner cache an invalidate and waits for confirmation in a dedicated drain state. A stalled event produces no actions and must be presented again later. The wake strobe tells the event queues when a retry is worthwhile. An event that has no meaning in the current state leaves the state unchanged and sets a sticky error flag.

Top module: `coh_line_ctrl`

## Requirements
- R1: State codes are INV=0, SH_IN=1, SH=2, EX_IN=3, EX=4, MD_IN=5, MD=6, WT_SH=7, WT_EX=8, WT_UPG=9, WT_PUT=10, WT_PUTSINK=11, DRN_SH=12, DRN_EX=13, DRN_MD=14, DRN_MDWB=15 and DRN_UPG=16. Event codes are LOAD=0, STORE=1, INNER_WB=2, INNER_DATA_ACK=3, INNER_ACK=4, OUT_INV=5, RECALL_OWN=6, RECALL_OTHER=7, REPLACE=8, FWD_EX=9, FWD_SH=10, DATA_PART=11, DATA_EXCL=12, DATA_PEER=13, DATA_LAST=14, ACK_PART=15, ACK_LAST=16 and WB_ACK=17. While reset is held, rsp_valid_o=0, err_o=0 and nxt_state_o=INV.
- R2: The act_o bits are 0 req_sh, 1 req_ex, 2 req_upg, 3 data_req, 4 data_outer, 5 ack, 6 unblock, 7 unblock_ex, 8 put, 9 put_data, 10 inner_inv, 11 inner_sh, 12 inner_ex, 13 tbe_alloc, 14 tbe_free, 15 line_alloc, 16 line_free, 17 wake, 18 miss and 19 hit. An event presented with ev_valid_i produces its result on the outputs one cycle later, with rsp_valid_o=1. A cycle with no event gives rsp_valid_o=0 and act_o=0 one cycle later.
- R3: In INV, LOAD goes to WT_SH with req_sh, and STORE goes to WT_EX with req_ex. Both also raise line_alloc, tbe_alloc and miss.
- R4: LOAD in SH or SH_IN goes to SH_IN with inner_sh and hit. LOAD in EX goes to EX_IN, and LOAD in MD goes to MD_IN, both with inner_ex and hit. STORE in EX or MD goes to MD_IN with inner_ex and hit. STORE in SH or SH_IN goes to WT_UPG with req_upg, tbe_alloc and miss.
- R5: REPLACE in EX or MD goes to WT_PUT with tbe_alloc, put and line_free, and also put_data exactly when dirty_i=1. REPLACE in SH goes to INV with line_free only. WB_ACK in WT_PUT or WT_PUTSINK goes to INV with tbe_free and line_free.
- R6: FWD_EX in EX or MD goes to INV with data_req and line_free. FWD_SH in EX or MD goes to SH with data_req and data_outer. In WT_PUT, FWD_EX goes to WT_PUTSINK with data_req, and FWD_SH goes to WT_PUTSINK with data_req and data_outer.
- R7: OUT_INV in MD goes to INV with data_outer and line_free. OUT_INV in SH or EX goes to INV with ack and line_free. In INV and WT_PUTSINK it stays put with ack. In WT_PUT it goes to WT_PUTSINK with data_outer. In WT_EX or WT_UPG it goes to WT_EX with ack.
- R8: RECALL_OWN or RECALL_OTHER in SH_IN, EX_IN or MD_IN goes to DRN_SH, DRN_EX or DRN_MD with inner_inv. RECALL_OTHER in WT_UPG goes to DRN_UPG with inner_inv. INNER_ACK leads from DRN_SH to SH, from DRN_EX to EX, from DRN_MD or DRN_MDWB to MD, and from DRN_UPG to WT_EX. In DRN_EX or DRN_MD, INNER_DATA_ACK goes to MD and INNER_WB goes to DRN_MDWB. INNER_WB in EX_IN or MD_IN goes to MD with no strobe.
- R9: In WT_SH, DATA_EXCL goes to EX_IN with inner_ex and unblock_ex. DATA_PEER goes to SH_IN with inner_sh and unblock. DATA_LAST goes to SH_IN with inner_sh. In WT_EX, DATA_LAST goes to MD_IN with inner_ex and unblock_ex, and DATA_PART goes to WT_UPG. ACK_LAST in WT_UPG goes to MD_IN with inner_ex and unblock_ex. ACK_PART keeps WT_EX or WT_UPG. Every fill that completes also raises tbe_free.
- R10: LOAD, STORE and REPLACE stall in every state from 7 to 16. OUT_INV, FWD_EX and FWD_SH stall in WT_SH and in every DRN state. RECALL_OWN stalls in WT_UPG and in every DRN state. RECALL_OTHER stalls in every DRN state. A stall sets stall_o=1, keeps the state and gives act_o=0.
- R11: Any other event and state pair, including a state code above 16, keeps the state and gives act_o=0 and stall_o=0. It also sets err_o, which then stays at 1 until reset.
- R12: wake is raised with every tbe_free, and with every event a DRN state accepts without stalling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_valid_i | input | 1 | An event is presented this cycle |
| ev_i | input | 5 | Decoded event code |
| state_i | input | 5 | Current state of the addressed line |
| dirty_i | input | 1 | Line holds modified data |
| rsp_valid_o | output | 1 | Result of the previous cycle's event is valid |
| nxt_state_o | output | 5 | State to write back for the line |
| act_o | output | 20 | Action strobes |
| stall_o | output | 1 | Event was not consumed |
| err_o | output | 1 | Sticky illegal-event flag |

## Verification
The checker assumes that state_i is the code last written back for the line being addressed. It also assumes that ev_valid_i marks each cycle whose event should produce a response. It relies on every result appearing exactly one cycle after its event. The bench drives a single event per cycle, each pairing a chosen state with a chosen event. It keeps to legal and stalling combinations until the final phase, where the illegal ones are applied. That ordering means the sticky error flag, once set, does not hide the earlier results, and a second reset shows the flag clearing.

// File: rtl/coh_line_pkg.sv
package coh_line_pkg;
  localparam int ST_W  = 5;
  localparam int EV_W  = 5;
  localparam int ACT_W = 20;

  typedef enum logic [ST_W-1:0] {
    ST_INV = 5'd0, ST_SH_IN = 5'd1, ST_SH = 5'd2, ST_EX_IN = 5'd3, ST_EX = 5'd4,
    ST_MD_IN = 5'd5, ST_MD = 5'd6, ST_WT_SH = 5'd7, ST_WT_EX = 5'd8,
    ST_WT_UPG = 5'd9, ST_WT_PUT = 5'd10, ST_WT_PUTSINK = 5'd11,
    ST_DRN_SH = 5'd12, ST_DRN_EX = 5'd13, ST_DRN_MD = 5'd14,
    ST_DRN_MDWB = 5'd15, ST_DRN_UPG = 5'd16
  } line_st_e;

  typedef enum logic [EV_W-1:0] {
    EV_LOAD = 5'd0, EV_STORE = 5'd1, EV_INNER_WB = 5'd2, EV_INNER_DATA_ACK = 5'd3,
    EV_INNER_ACK = 5'd4, EV_OUT_INV = 5'd5, EV_RECALL_OWN = 5'd6,
    EV_RECALL_OTHER = 5'd7, EV_REPLACE = 5'd8, EV_FWD_EX = 5'd9, EV_FWD_SH = 5'd10,
    EV_DATA_PART = 5'd11, EV_DATA_EXCL = 5'd12, EV_DATA_PEER = 5'd13,
    EV_DATA_LAST = 5'd14, EV_ACK_PART = 5'd15, EV_ACK_LAST = 5'd16, EV_WB_ACK = 5'd17
  } line_ev_e;

  localparam int A_REQ_SH     = 0;
  localparam int A_REQ_EX     = 1;
  localparam int A_REQ_UPG    = 2;
  localparam int A_DATA_REQ   = 3;
  localparam int A_DATA_OUTER = 4;
  localparam int A_ACK        = 5;
  localparam int A_UNBLOCK    = 6;
  localparam int A_UNBLOCK_EX = 7;
  localparam int A_PUT        = 8;
  localparam int A_PUT_DATA   = 9;
  localparam int A_INNER_INV  = 10;
  localparam int A_INNER_SH   = 11;
  localparam int A_INNER_EX   = 12;
  localparam int A_TBE_ALLOC  = 13;
  localparam int A_TBE_FREE   = 14;
  localparam int A_LINE_ALLOC = 15;
  localparam int A_LINE_FREE  = 16;
  localparam int A_WAKE       = 17;
  localparam int A_MISS       = 18;
  localparam int A_HIT        = 19;
endpackage

// File: rtl/coh_line_gate.sv
module coh_line_gate
  import coh_line_pkg::*;
(
  input  line_st_e st_i,
  input  line_ev_e ev_i,
  output logic     stall_o,
  output logic     drain_o
);
  logic trans, cpu_ev, outer_ev;

  always_comb begin
    trans    = (st_i >= ST_WT_SH) && (st_i <= ST_DRN_UPG);
    drain_o  = (st_i >= ST_DRN_SH) && (st_i <= ST_DRN_UPG);
    cpu_ev   = (ev_i == EV_LOAD) || (ev_i == EV_STORE) || (ev_i == EV_REPLACE);
    outer_ev = (ev_i == EV_OUT_INV) || (ev_i == EV_FWD_EX) || (ev_i == EV_FWD_SH);
    stall_o  = (cpu_ev && trans)
            || (outer_ev && (drain_o || st_i == ST_WT_SH))
            || ((ev_i == EV_RECALL_OWN) && (drain_o || st_i == ST_WT_UPG))
            || ((ev_i == EV_RECALL_OTHER) && drain_o);
  end
endmodule

// File: rtl/coh_line_xition.sv
module coh_line_xition
  import coh_line_pkg::*;
(
  input  line_st_e         st_i,
  input  line_ev_e         ev_i,
  input  logic             dirty_i,
  input  logic             stall_i,
  input  logic             drain_i,
  output line_st_e         nxt_o,
  output logic [ACT_W-1:0] act_o,
  output logic             bad_o
);
  logic [ACT_W-1:0] a;

  always_comb begin
    nxt_o = st_i;
    a     = '0;
    bad_o = 1'b1;
    if (stall_i) begin
      bad_o = 1'b0;
    end else begin
      case (st_i)
        ST_INV: case (ev_i)
          EV_LOAD: begin
            nxt_o = ST_WT_SH; bad_o = 1'b0;
            a[A_REQ_SH] = 1'b1; a[A_LINE_ALLOC] = 1'b1; a[A_TBE_ALLOC] = 1'b1; a[A_MISS] = 1'b1;
          end
          EV_STORE: begin
            nxt_o = ST_WT_EX; bad_o = 1'b0;
            a[A_REQ_EX] = 1'b1; a[A_LINE_ALLOC] = 1'b1; a[A_TBE_ALLOC] = 1'b1; a[A_MISS] = 1'b1;
          end
          EV_OUT_INV: begin bad_o = 1'b0; a[A_ACK] = 1'b1; end
          default: ;
        endcase
        ST_SH_IN, ST_SH: case (ev_i)
          EV_LOAD: begin nxt_o = ST_SH_IN; bad_o = 1'b0; a[A_INNER_SH] = 1'b1; a[A_HIT] = 1'b1; end
          EV_STORE: begin
            nxt_o = ST_WT_UPG; bad_o = 1'b0;
            a[A_REQ_UPG] = 1'b1; a[A_TBE_ALLOC] = 1'b1; a[A_MISS] = 1'b1;
          end
          EV_REPLACE: if (st_i == ST_SH) begin
            nxt_o = ST_INV; bad_o = 1'b0; a[A_LINE_FREE] = 1'b1;
          end
          EV_OUT_INV: if (st_i == ST_SH) begin
            nxt_o = ST_INV; bad_o = 1'b0; a[A_ACK] = 1'b1; a[A_LINE_FREE] = 1'b1;
          end
          EV_RECALL_OWN, EV_RECALL_OTHER: if (st_i == ST_SH_IN) begin
            nxt_o = ST_DRN_SH; bad_o = 1'b0; a[A_INNER_INV] = 1'b1;
          end
          default: ;
        endcase
        ST_EX, ST_MD: case (ev_i)
          EV_LOAD: begin
            nxt_o = (st_i == ST_EX) ? ST_EX_IN : ST_MD_IN; bad_o = 1'b0;
            a[A_INNER_EX] = 1'b1; a[A_HIT] = 1'b1;
          end
          EV_STORE: begin nxt_o = ST_MD_IN; bad_o = 1'b0; a[A_INNER_EX] = 1'b1; a[A_HIT] = 1'b1; end
          EV_REPLACE: begin
            nxt_o = ST_WT_PUT; bad_o = 1'b0;
            a[A_TBE_ALLOC] = 1'b1; a[A_PUT] = 1'b1; a[A_PUT_DATA] = dirty_i; a[A_LINE_FREE] = 1'b1;
          end
          EV_OUT_INV: begin
            nxt_o = ST_INV; bad_o = 1'b0; a[A_LINE_FREE] = 1'b1;
            if (st_i == ST_MD) a[A_DATA_OUTER] = 1'b1;
            else a[A_ACK] = 1'b1;
          end
          EV_FWD_EX: begin nxt_o = ST_INV; bad_o = 1'b0; a[A_DATA_REQ] = 1'b1; a[A_LINE_FREE] = 1'b1; end
          EV_FWD_SH: begin nxt_o = ST_SH; bad_o = 1'b0; a[A_DATA_REQ] = 1'b1; a[A_DATA_OUTER] = 1'b1; end
          default: ;
        endcase
        ST_EX_IN, ST_MD_IN: case (ev_i)
          EV_RECALL_OWN, EV_RECALL_OTHER: begin
            nxt_o = (st_i == ST_EX_IN) ? ST_DRN_EX : ST_DRN_MD; bad_o = 1'b0; a[A_INNER_INV] = 1'b1;
          end
          EV_INNER_WB: begin nxt_o = ST_MD; bad_o = 1'b0; end
          default: ;
        endcase
        ST_WT_PUT, ST_WT_PUTSINK: case (ev_i)
          EV_WB_ACK: begin nxt_o = ST_INV; bad_o = 1'b0; a[A_TBE_FREE] = 1'b1; a[A_LINE_FREE] = 1'b1; end
          EV_OUT_INV: begin
            nxt_o = ST_WT_PUTSINK; bad_o = 1'b0;
            if (st_i == ST_WT_PUT) a[A_DATA_OUTER] = 1'b1;
            else a[A_ACK] = 1'b1;
          end
          EV_FWD_EX: if (st_i == ST_WT_PUT) begin
            nxt_o = ST_WT_PUTSINK; bad_o = 1'b0; a[A_DATA_REQ] = 1'b1;
          end
          EV_FWD_SH: if (st_i == ST_WT_PUT) begin
            nxt_o = ST_WT_PUTSINK; bad_o = 1'b0; a[A_DATA_REQ] = 1'b1; a[A_DATA_OUTER] = 1'b1;
          end
          default: ;
        endcase
        ST_WT_SH: case (ev_i)
          EV_DATA_EXCL: begin
            nxt_o = ST_EX_IN; bad_o = 1'b0;
            a[A_INNER_EX] = 1'b1; a[A_UNBLOCK_EX] = 1'b1; a[A_TBE_FREE] = 1'b1;
          end
          EV_DATA_PEER: begin
            nxt_o = ST_SH_IN; bad_o = 1'b0;
            a[A_INNER_SH] = 1'b1; a[A_UNBLOCK] = 1'b1; a[A_TBE_FREE] = 1'b1;
          end
          EV_DATA_LAST: begin nxt_o = ST_SH_IN; bad_o = 1'b0; a[A_INNER_SH] = 1'b1; a[A_TBE_FREE] = 1'b1; end
          default: ;
        endcase
        ST_WT_EX, ST_WT_UPG: case (ev_i)
          EV_OUT_INV: begin nxt_o = ST_WT_EX; bad_o = 1'b0; a[A_ACK] = 1'b1; end
          EV_ACK_PART: bad_o = 1'b0;
          EV_DATA_PART: if (st_i == ST_WT_EX) begin nxt_o = ST_WT_UPG; bad_o = 1'b0; end
          EV_DATA_LAST, EV_ACK_LAST:
            if ((st_i == ST_WT_EX) == (ev_i == EV_DATA_LAST)) begin
              nxt_o = ST_MD_IN; bad_o = 1'b0;
              a[A_INNER_EX] = 1'b1; a[A_UNBLOCK_EX] = 1'b1; a[A_TBE_FREE] = 1'b1;
            end
          EV_RECALL_OTHER: if (st_i == ST_WT_UPG) begin
            nxt_o = ST_DRN_UPG; bad_o = 1'b0; a[A_INNER_INV] = 1'b1;
          end
          default: ;
        endcase
        ST_DRN_SH: if (ev_i == EV_INNER_ACK) begin nxt_o = ST_SH; bad_o = 1'b0; end
        ST_DRN_EX, ST_DRN_MD: case (ev_i)
          EV_INNER_WB: begin nxt_o = ST_DRN_MDWB; bad_o = 1'b0; end
          EV_INNER_DATA_ACK: begin nxt_o = ST_MD; bad_o = 1'b0; end
          EV_INNER_ACK: begin nxt_o = (st_i == ST_DRN_EX) ? ST_EX : ST_MD; bad_o = 1'b0; end
          default: ;
        endcase
        ST_DRN_MDWB: if (ev_i == EV_INNER_ACK) begin nxt_o = ST_MD; bad_o = 1'b0; end
        ST_DRN_UPG: if (ev_i == EV_INNER_ACK) begin nxt_o = ST_WT_EX; bad_o = 1'b0; end
        default: ;
      endcase
    end
    if (bad_o) nxt_o = st_i;
    act_o = a;
    act_o[A_WAKE] = a[A_TBE_FREE] || (drain_i && !bad_o && !stall_i);
  end
endmodule

// File: rtl/coh_line_rsp.sv
module coh_line_rsp
  import coh_line_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  line_st_e         nxt_i,
  input  logic [ACT_W-1:0] act_i,
  input  logic             stall_i,
  input  logic             bad_i,
  output logic             valid_o,
  output logic [ST_W-1:0]  nxt_o,
  output logic [ACT_W-1:0] act_o,
  output logic             stall_o,
  output logic             err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      nxt_o   <= ST_INV;
      act_o   <= '0;
      stall_o <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      act_o   <= valid_i ? act_i : '0;
      stall_o <= valid_i & stall_i;
      if (valid_i) nxt_o <= nxt_i;
      if (valid_i && bad_i) err_o <= 1'b1;
    end
  end
endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
  import coh_line_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ev_valid_i,
  input  logic [EV_W-1:0]  ev_i,
  input  logic [ST_W-1:0]  state_i,
  input  logic             dirty_i,
  output logic             rsp_valid_o,
  output logic [ST_W-1:0]  nxt_state_o,
  output logic [ACT_W-1:0] act_o,
  output logic             stall_o,
  output logic             err_o
);
  line_st_e         st;
  line_ev_e         ev;
  line_st_e         nxt;
  logic [ACT_W-1:0] act;
  logic             stall, drain, bad;

  assign st = line_st_e'(state_i);
  assign ev = line_ev_e'(ev_i);

  coh_line_gate u_gate (
    .st_i(st), .ev_i(ev), .stall_o(stall), .drain_o(drain)
  );

  coh_line_xition u_xition (
    .st_i(st), .ev_i(ev), .dirty_i(dirty_i), .stall_i(stall), .drain_i(drain),
    .nxt_o(nxt), .act_o(act), .bad_o(bad)
  );

  coh_line_rsp u_rsp (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(ev_valid_i), .nxt_i(nxt), .act_i(act),
    .stall_i(stall), .bad_i(bad), .valid_o(rsp_valid_o), .nxt_o(nxt_state_o),
    .act_o(act_o), .stall_o(stall_o), .err_o(err_o)
  );
endmodule

// File: rtl/coh_line_ctrl_chk.sv
module coh_line_ctrl_chk
  import coh_line_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ev_valid_i,
  input logic [ST_W-1:0]  state_i,
  input logic             rsp_valid_o,
  input logic [ST_W-1:0]  nxt_state_o,
  input logic [ACT_W-1:0] act_o,
  input logic             stall_o,
  input logic             err_o
);
  a_r2_rsp_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_valid_i |=> rsp_valid_o);
  a_r2_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ev_valid_i |=> (!rsp_valid_o && act_o == '0));
  a_r10_stall_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_valid_i && state_i <= ST_W'(ST_DRN_UPG)) ##1 stall_o |-> (nxt_state_o == $past(state_i) && act_o == '0));
  a_r11_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  a_r3_alloc_from_inv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_valid_i ##1 act_o[A_LINE_ALLOC] |-> $past(state_i) == ST_W'(ST_INV));
  a_r12_free_wakes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_o[A_TBE_FREE] |-> act_o[A_WAKE]);
  a_r3_one_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({act_o[A_REQ_SH], act_o[A_REQ_EX], act_o[A_REQ_UPG]}));
  a_r9_one_unblock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({act_o[A_UNBLOCK], act_o[A_UNBLOCK_EX]}));
endmodule

bind coh_line_ctrl coh_line_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ev_valid_i(ev_valid_i), .state_i(state_i),
  .rsp_valid_o(rsp_valid_o), .nxt_state_o(nxt_state_o), .act_o(act_o),
  .stall_o(stall_o), .err_o(err_o)
);

// File: tb/coh_line_ctrl_bench.sv
module coh_line_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG = 5000;

  localparam logic [19:0] B_RSH = 20'h00001, B_REX = 20'h00002, B_RUPG = 20'h00004,
    B_DREQ = 20'h00008, B_DOUT = 20'h00010, B_ACK = 20'h00020, B_UB = 20'h00040,
    B_UBX = 20'h00080, B_PUT = 20'h00100, B_PUTD = 20'h00200, B_IINV = 20'h00400,
    B_ISH = 20'h00800, B_IEX = 20'h01000, B_TAL = 20'h02000, B_TFR = 20'h04000,
    B_LAL = 20'h08000, B_LFR = 20'h10000, B_WAKE = 20'h20000, B_MISS = 20'h40000,
    B_HIT = 20'h80000;

  localparam int S_I = 0, S_SHI = 1, S_SH = 2, S_EXI = 3, S_EX = 4, S_MDI = 5, S_MD = 6,
    S_WSH = 7, S_WEX = 8, S_WUP = 9, S_WPUT = 10, S_SINK = 11, S_DSH = 12, S_DEX = 13,
    S_DMD = 14, S_DMW = 15, S_DUP = 16;
  localparam int E_LD = 0, E_ST = 1, E_IWB = 2, E_IDA = 3, E_IACK = 4, E_OINV = 5,
    E_ROWN = 6, E_ROTH = 7, E_REPL = 8, E_FEX = 9, E_FSH = 10, E_DPART = 11,
    E_DEXC = 12, E_DPEER = 13, E_DLAST = 14, E_APART = 15, E_ALAST = 16, E_WBACK = 17;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_valid = 1'b0, dirty = 1'b0;
  logic [4:0] ev = '0, st = '0;
  logic rsp_valid, stall, err;
  logic [4:0] nxt;
  logic [19:0] act;

  int checks = 0, fails = 0;
  logic err_model = 1'b0;
  bit done = 1'b0;

  logic [4:0]  q_nxt[$];
  logic [19:0] q_act[$];
  logic        q_stall[$];
  logic        q_err[$];
  string       q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  coh_line_ctrl u_coh_line_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .ev_valid_i(ev_valid), .ev_i(ev), .state_i(st),
    .dirty_i(dirty), .rsp_valid_o(rsp_valid), .nxt_state_o(nxt), .act_o(act),
    .stall_o(stall), .err_o(err)
  );

  task automatic drive(input int s, input int e, input logic d, input int xn,
                       input logic [19:0] xa, input logic xs, input logic bad, input string tag);
    @(negedge clk);
    st = s[4:0]; ev = e[4:0]; dirty = d; ev_valid = 1'b1;
    if (bad) err_model = 1'b1;
    q_nxt.push_back(xn[4:0]); q_act.push_back(xa); q_stall.push_back(xs);
    q_err.push_back(err_model); q_tag.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ev_valid = 1'b0;
    end
  endtask

  task automatic check_bit(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      checks++;
      if (q_nxt.size() == 0) begin
        fails++;
        $display("FAIL R2: unexpected response nxt=%0d act=%h, expected none", nxt, act);
      end else begin
        logic [4:0] xn; logic [19:0] xa; logic xs, xe; string tg;
        xn = q_nxt.pop_front(); xa = q_act.pop_front(); xs = q_stall.pop_front();
        xe = q_err.pop_front(); tg = q_tag.pop_front();
        if (nxt !== xn || act !== xa || stall !== xs || err !== xe) begin
          fails++;
          $display("FAIL %s: got nxt=%0d act=%h stall=%b err=%b expected nxt=%0d act=%h stall=%b err=%b",
                   tg, nxt, act, stall, err, xn, xa, xs, xe);
        end
      end
    end
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_bit(rsp_valid, 1'b0, "R1 reset valid");
    check_bit(err, 1'b0, "R1 reset err");
    check_bit(nxt == 5'd0, 1'b1, "R1 reset state INV");
    @(negedge clk); rst_n = 1'b1;

    // R3 misses
    drive(S_I, E_LD, 0, S_WSH, B_RSH|B_LAL|B_TAL|B_MISS, 0, 0, "R3 load in INV");
    drive(S_I, E_ST, 0, S_WEX, B_REX|B_LAL|B_TAL|B_MISS, 0, 0, "R3 store in INV");
    // R4 hits and upgrade
    drive(S_SH, E_LD, 0, S_SHI, B_ISH|B_HIT, 0, 0, "R4 load SH");
    drive(S_SHI, E_LD, 0, S_SHI, B_ISH|B_HIT, 0, 0, "R4 load SH_IN");
    drive(S_EX, E_LD, 0, S_EXI, B_IEX|B_HIT, 0, 0, "R4 load EX");
    drive(S_MD, E_LD, 0, S_MDI, B_IEX|B_HIT, 0, 0, "R4 load MD");
    drive(S_EX, E_ST, 0, S_MDI, B_IEX|B_HIT, 0, 0, "R4 store EX");
    drive(S_SH, E_ST, 0, S_WUP, B_RUPG|B_TAL|B_MISS, 0, 0, "R4 store SH");
    drive(S_SHI, E_ST, 0, S_WUP, B_RUPG|B_TAL|B_MISS, 0, 0, "R4 store SH_IN");
    // R5 replacement
    drive(S_EX, E_REPL, 0, S_WPUT, B_TAL|B_PUT|B_LFR, 0, 0, "R5 replace EX clean");
    drive(S_MD, E_REPL, 1, S_WPUT, B_TAL|B_PUT|B_PUTD|B_LFR, 0, 0, "R5 replace MD dirty");
    drive(S_SH, E_REPL, 0, S_I, B_LFR, 0, 0, "R5 replace SH silent");
    drive(S_WPUT, E_WBACK, 0, S_I, B_TFR|B_LFR|B_WAKE, 0, 0, "R5 R12 wb ack WT_PUT");
    drive(S_SINK, E_WBACK, 0, S_I, B_TFR|B_LFR|B_WAKE, 0, 0, "R5 R12 wb ack WT_PUTSINK");
    // R6 forwards
    drive(S_EX, E_FEX, 0, S_I, B_DREQ|B_LFR, 0, 0, "R6 fwd ex EX");
    drive(S_MD, E_FSH, 0, S_SH, B_DREQ|B_DOUT, 0, 0, "R6 fwd sh MD");
    drive(S_WPUT, E_FSH, 0, S_SINK, B_DREQ|B_DOUT, 0, 0, "R6 fwd sh WT_PUT");
    drive(S_WPUT, E_FEX, 0, S_SINK, B_DREQ, 0, 0, "R6 fwd ex WT_PUT");
    // R7 outer invalidate
    drive(S_MD, E_OINV, 0, S_I, B_DOUT|B_LFR, 0, 0, "R7 inv MD");
    drive(S_EX, E_OINV, 0, S_I, B_ACK|B_LFR, 0, 0, "R7 inv EX");
    drive(S_SH, E_OINV, 0, S_I, B_ACK|B_LFR, 0, 0, "R7 inv SH");
    drive(S_I, E_OINV, 0, S_I, B_ACK, 0, 0, "R7 inv INV");
    drive(S_WPUT, E_OINV, 0, S_SINK, B_DOUT, 0, 0, "R7 inv WT_PUT");
    drive(S_SINK, E_OINV, 0, S_SINK, B_ACK, 0, 0, "R7 inv WT_PUTSINK");
    drive(S_WUP, E_OINV, 0, S_WEX, B_ACK, 0, 0, "R7 inv WT_UPG");
    // R8 recall / drain
    drive(S_SHI, E_ROWN, 0, S_DSH, B_IINV, 0, 0, "R8 recall own SH_IN");
    drive(S_MDI, E_ROTH, 0, S_DMD, B_IINV, 0, 0, "R8 recall other MD_IN");
    drive(S_EXI, E_ROWN, 0, S_DEX, B_IINV, 0, 0, "R8 recall own EX_IN");
    drive(S_WUP, E_ROTH, 0, S_DUP, B_IINV, 0, 0, "R8 recall other WT_UPG");
    drive(S_DSH, E_IACK, 0, S_SH, B_WAKE, 0, 0, "R8 R12 inner ack DRN_SH");
    drive(S_DEX, E_IACK, 0, S_EX, B_WAKE, 0, 0, "R8 R12 inner ack DRN_EX");
    drive(S_DMW, E_IACK, 0, S_MD, B_WAKE, 0, 0, "R8 R12 inner ack DRN_MDWB");
    drive(S_DMD, E_IDA, 0, S_MD, B_WAKE, 0, 0, "R8 R12 inner data ack DRN_MD");
    drive(S_DEX, E_IWB, 0, S_DMW, B_WAKE, 0, 0, "R8 R12 inner wb DRN_EX");
    drive(S_DUP, E_IACK, 0, S_WEX, B_WAKE, 0, 0, "R8 R12 inner ack DRN_UPG");
    drive(S_EXI, E_IWB, 0, S_MD, 20'h0, 0, 0, "R8 inner wb EX_IN");
    // R9 fills
    drive(S_WSH, E_DEXC, 0, S_EXI, B_IEX|B_UBX|B_TFR|B_WAKE, 0, 0, "R9 excl data WT_SH");
    drive(S_WSH, E_DPEER, 0, S_SHI, B_ISH|B_UB|B_TFR|B_WAKE, 0, 0, "R9 peer data WT_SH");
    drive(S_WSH, E_DLAST, 0, S_SHI, B_ISH|B_TFR|B_WAKE, 0, 0, "R9 last data WT_SH");
    drive(S_WEX, E_DPART, 0, S_WUP, 20'h0, 0, 0, "R9 partial data WT_EX");
    drive(S_WEX, E_DLAST, 0, S_MDI, B_IEX|B_UBX|B_TFR|B_WAKE, 0, 0, "R9 last data WT_EX");
    drive(S_WUP, E_APART, 0, S_WUP, 20'h0, 0, 0, "R9 partial ack WT_UPG");
    drive(S_WUP, E_ALAST, 0, S_MDI, B_IEX|B_UBX|B_TFR|B_WAKE, 0, 0, "R9 last ack WT_UPG");
    // R10 stalls
    drive(S_WSH, E_LD, 0, S_WSH, 20'h0, 1, 0, "R10 load WT_SH");
    drive(S_SINK, E_REPL, 0, S_SINK, 20'h0, 1, 0, "R10 replace WT_PUTSINK");
    drive(S_DMW, E_ST, 0, S_DMW, 20'h0, 1, 0, "R10 store DRN_MDWB");
    drive(S_DMD, E_FEX, 0, S_DMD, 20'h0, 1, 0, "R10 fwd DRN_MD");
    drive(S_WSH, E_OINV, 0, S_WSH, 20'h0, 1, 0, "R10 inv WT_SH");
    drive(S_WUP, E_ROWN, 0, S_WUP, 20'h0, 1, 0, "R10 recall own WT_UPG");
    drive(S_DUP, E_ROTH, 0, S_DUP, 20'h0, 1, 0, "R10 recall other DRN_UPG");
    // R2 idle
    idle(1);
    @(negedge clk);
    check_bit(rsp_valid, 1'b0, "R2 idle valid");
    check_bit(act == 20'h0, 1'b1, "R2 idle act");
    // R11 illegal
    drive(S_EXI, E_ST, 0, S_EXI, 20'h0, 0, 1, "R11 store EX_IN illegal");
    drive(S_I, E_LD, 0, S_WSH, B_RSH|B_LAL|B_TAL|B_MISS, 0, 0, "R11 err stays set");
    drive(20, E_LD, 0, 20, 20'h0, 0, 1, "R11 bad state code");
    idle(3);
    rst_n = 1'b0;
    @(negedge clk);
    check_bit(err, 1'b0, "R11 err cleared by reset");
    check_bit(rsp_valid, 1'b0, "R1 valid low in reset");
    rst_n = 1'b1;
    idle(2);
    check_bit(q_nxt.size() == 0, 1'b1, "R2 all responses seen");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule